// File: doc/BRIEF.md
# Serial EEPROM Protection and Page Command Responder

This block is the byte-level command engine of a two-wire presence-detect EEPROM. A bit/byte front-end hands it START and STOP pulses and each byte the master sends; the engine returns an acknowledge decision for every byte. It recognises a small set of reserved command addresses. These let the master protect one quarter of the array, clear all protection at once, choose which half of the array is visible, and ask about protection or page state.

Every answer is carried by the ACK/NoACK bit alone. Read bytes during a query are dummy 0xFF. The engine keeps one protection flag per block and the active-page bit, and it changes them only at a STOP that closes a complete, accepted command. It pulses a write-cycle request when a protection change must be programmed. While an external busy input is high, any new command is refused.

The state machine has seven states:
- ST_IDLE waits for START.
- ST_CMD takes the command byte.
- ST_ADDR and ST_DATA take the dummy address and data bytes of a write command.
- ST_TAIL waits for the closing STOP.
- ST_QUERY holds a read query until STOP.
- ST_SKIP refuses every byte until the next START.

The transitions are:
- START moves any state to ST_CMD.
- STOP moves any state to ST_IDLE, and commits the command only from ST_TAIL.
- A byte moves ST_CMD to ST_ADDR (write command), ST_QUERY (query) or ST_SKIP (unknown command or busy).
- A byte moves ST_ADDR to ST_DATA, and ST_DATA to ST_TAIL.
- A byte moves ST_TAIL to ST_SKIP.

Top module: `spd_cmd_responder`

## Requirements
- R1: After reset the active page is 0, all four protection flags are clear, no write-cycle request is raised and no acknowledge is pending.
- R2: Byte 0x60+2b (b = block 0..3, R/W bit 0 = 0) on an unprotected block gets ACK. The two following dummy bytes also get ACK. The STOP that follows sets the flag of block b and gives a one-cycle write-cycle request.
- R3: The same set command on a block that is already protected gets NoACK on the command and on both dummy bytes. Its STOP starts no write cycle and changes no flag.
- R4: Byte 0x68 (clear-all) gets ACK on the command and on both dummy bytes, whatever the flags are. Its STOP clears every flag and gives a write-cycle request.
- R5: Bytes 0x6A (page 0) and 0x6C (page 1) get ACK on the command and on the address byte, and NoACK on the data byte. The page changes at the STOP that follows, and no write-cycle request is raised.
- R6: Byte 0x61+2b (protection query) gets ACK if block b is unprotected and NoACK if it is protected. Read data is 0xFF, and no state changes.
- R7: Byte 0x6B (page query) gets ACK when page 0 is active and NoACK when page 1 is active.
- R8: Any other first byte, including 0x69 and 0x6D, gets NoACK. Every later byte up to the next START also gets NoACK.
- R9: A repeated START or a STOP before the data byte aborts the command and leaves the flags and the page unchanged.
- R10: While busy is high, a command byte gets NoACK, its later bytes get NoACK, and nothing is committed.
- R11: A byte after the data byte of a write command gets NoACK, and the command is then discarded at STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | START or repeated START seen (pulse) |
| stop_i | input | 1 | STOP seen (pulse) |
| byte_vld_i | input | 1 | A byte from the master is complete (pulse) |
| byte_i | input | 8 | Received byte |
| busy_i | input | 1 | A write cycle is in progress |
| ack_vld_o | output | 1 | Acknowledge decision valid, one cycle after byte_vld_i |
| ack_o | output | 1 | 1 = ACK, 0 = NoACK |
| rd_data_o | output | 8 | Dummy read byte (0xFF) |
| wc_req_o | output | 1 | One-cycle write-cycle request |
| prot_o | output | 4 | Protection flag per block |
| page_o | output | 1 | Active page |

## Verification
The bench protects a block twice. A design that ignored the stored flag would ACK the second attempt and ask for a second write cycle. It runs a page select and then a page query. A design that launched a write cycle for the page, or that ACKed its data byte, would disagree with the scoreboard.

The bench also covers commands cut short by a repeated START, by an early STOP, by busy, and by a surplus byte. A design that committed on any STOP, rather than only one closing a complete command, would change the flags in these cases. Unknown addresses, and the clear-all address with the read bit set, must draw NoACK on every byte. A loose decoder would ACK them.

// File: rtl/spd_cmd_pkg.sv
package spd_cmd_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_SET,
        K_CLR,
        K_PG,
        K_QPROT,
        K_QPAGE
    } cmd_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_TAIL,
        ST_QUERY,
        ST_SKIP
    } cmd_state_t;

endpackage

// File: rtl/spd_cmd_decode.sv
module spd_cmd_decode
    import spd_cmd_pkg::*;
#(
    parameter int          NBLK     = 4,
    parameter logic [6:0]  CMD_BASE = 7'h30,
    localparam int         BW       = $clog2(NBLK)
) (
    input  logic [7:0]    byte_i,
    output cmd_kind_t     kind_o,
    output logic [BW-1:0] blk_o,
    output logic          pg_o
);
    logic [6:0] off;
    logic       rd;

    assign off = byte_i[7:1] - CMD_BASE;
    assign rd  = byte_i[0];

    always_comb begin
        kind_o = K_NONE;
        blk_o  = off[BW-1:0];
        pg_o   = 1'b0;
        if (off < 7'(NBLK)) begin
            kind_o = rd ? K_QPROT : K_SET;
        end else if (off == 7'(NBLK) && !rd) begin
            kind_o = K_CLR;
        end else if (off == 7'(NBLK + 1)) begin
            kind_o = rd ? K_QPAGE : K_PG;
        end else if (off == 7'(NBLK + 2) && !rd) begin
            kind_o = K_PG;
            pg_o   = 1'b1;
        end
    end
endmodule

// File: rtl/spd_prot_store.sv
module spd_prot_store
    import spd_cmd_pkg::*;
#(
    parameter int  NBLK = 4,
    localparam int BW   = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_i,
    input  cmd_kind_t       kind_i,
    input  logic [BW-1:0]   blk_i,
    input  logic            pg_i,
    output logic [NBLK-1:0] prot_o,
    output logic            page_o,
    output logic            wc_req_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_o   <= '0;
            page_o   <= 1'b0;
            wc_req_o <= 1'b0;
        end else begin
            wc_req_o <= 1'b0;
            if (commit_i) begin
                unique case (kind_i)
                    K_SET: begin
                        prot_o[blk_i] <= 1'b1;
                        wc_req_o      <= 1'b1;
                    end
                    K_CLR: begin
                        prot_o   <= '0;
                        wc_req_o <= 1'b1;
                    end
                    K_PG:    page_o <= pg_i;
                    default: ;
                endcase
            end
        end
    end

    // R3: the controller must never commit a set on a protected block
    p_no_double_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && kind_i == K_SET) |-> !prot_o[blk_i]);

    // R9: flags move only on a commit
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(prot_o));
endmodule

// File: rtl/spd_cmd_fsm.sv
module spd_cmd_fsm
    import spd_cmd_pkg::*;
#(
    parameter int  NBLK = 4,
    localparam int BW   = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic            byte_vld_i,
    input  logic            busy_i,
    input  cmd_kind_t       dec_kind_i,
    input  logic [BW-1:0]   dec_blk_i,
    input  logic            dec_pg_i,
    input  logic [NBLK-1:0] prot_i,
    input  logic            page_i,
    output logic            ack_vld_o,
    output logic            ack_o,
    output logic            commit_o,
    output cmd_kind_t       kind_o,
    output logic [BW-1:0]   blk_o,
    output logic            pg_o
);
    cmd_state_t    st, st_n;
    cmd_kind_t     kind_n;
    logic [BW-1:0] blk_n;
    logic          pg_n, ok, ok_n, ackv_n, ack_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            kind_o    <= K_NONE;
            blk_o     <= '0;
            pg_o      <= 1'b0;
            ok        <= 1'b0;
            ack_vld_o <= 1'b0;
            ack_o     <= 1'b0;
        end else begin
            st        <= st_n;
            kind_o    <= kind_n;
            blk_o     <= blk_n;
            pg_o      <= pg_n;
            ok        <= ok_n;
            ack_vld_o <= ackv_n;
            ack_o     <= ack_n;
        end
    end

    assign commit_o = stop_i && !start_i && (st == ST_TAIL) && ok;

    always_comb begin
        st_n   = st;
        kind_n = kind_o;
        blk_n  = blk_o;
        pg_n   = pg_o;
        ok_n   = ok;
        ackv_n = 1'b0;
        ack_n  = 1'b0;
        if (start_i) begin
            st_n = ST_CMD;
        end else if (stop_i) begin
            st_n = ST_IDLE;
        end else if (byte_vld_i) begin
            ackv_n = 1'b1;
            unique case (st)
                ST_CMD: begin
                    kind_n = dec_kind_i;
                    blk_n  = dec_blk_i;
                    pg_n   = dec_pg_i;
                    ok_n   = 1'b0;
                    st_n   = ST_SKIP;
                    if (!busy_i) begin
                        unique case (dec_kind_i)
                            K_SET: begin
                                ok_n  = !prot_i[dec_blk_i];
                                ack_n = !prot_i[dec_blk_i];
                                st_n  = ST_ADDR;
                            end
                            K_CLR, K_PG: begin
                                ok_n  = 1'b1;
                                ack_n = 1'b1;
                                st_n  = ST_ADDR;
                            end
                            K_QPROT: begin
                                ack_n = !prot_i[dec_blk_i];
                                st_n  = ST_QUERY;
                            end
                            K_QPAGE: begin
                                ack_n = !page_i;
                                st_n  = ST_QUERY;
                            end
                            default: st_n = ST_SKIP;
                        endcase
                    end
                end
                ST_ADDR: begin
                    ack_n = ok;
                    st_n  = ST_DATA;
                end
                ST_DATA: begin
                    ack_n = ok && (kind_o != K_PG);
                    st_n  = ST_TAIL;
                end
                ST_TAIL: st_n = ST_SKIP;
                default: ack_n = 1'b0;
            endcase
        end
    end

    // R10: a command byte taken while busy is refused
    p_busy_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && busy_i && st == ST_CMD && !start_i && !stop_i) |=> (ack_vld_o && !ack_o));

    // R5: the data byte of a page select is refused
    p_page_data_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && st == ST_DATA && kind_o == K_PG && !start_i && !stop_i) |=> !ack_o);

    // R8: nothing is acknowledged while skipping
    p_skip_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && st == ST_SKIP && !start_i && !stop_i) |=> !ack_o);
endmodule

// File: rtl/spd_cmd_responder.sv
module spd_cmd_responder
    import spd_cmd_pkg::*;
#(
    parameter int         NBLK     = 4,
    parameter int         DW       = 8,
    parameter logic [6:0] CMD_BASE = 7'h30,
    localparam int        BW       = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic            byte_vld_i,
    input  logic [7:0]      byte_i,
    input  logic            busy_i,
    output logic            ack_vld_o,
    output logic            ack_o,
    output logic [DW-1:0]   rd_data_o,
    output logic            wc_req_o,
    output logic [NBLK-1:0] prot_o,
    output logic            page_o
);
    cmd_kind_t     dec_kind, cur_kind;
    logic [BW-1:0] dec_blk, cur_blk;
    logic          dec_pg, cur_pg, commit;

    assign rd_data_o = '1;

    spd_cmd_decode #(.NBLK(NBLK), .CMD_BASE(CMD_BASE)) i_dec (
        .byte_i (byte_i),
        .kind_o (dec_kind),
        .blk_o  (dec_blk),
        .pg_o   (dec_pg)
    );

    spd_cmd_fsm #(.NBLK(NBLK)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .byte_vld_i (byte_vld_i),
        .busy_i     (busy_i),
        .dec_kind_i (dec_kind),
        .dec_blk_i  (dec_blk),
        .dec_pg_i   (dec_pg),
        .prot_i     (prot_o),
        .page_i     (page_o),
        .ack_vld_o  (ack_vld_o),
        .ack_o      (ack_o),
        .commit_o   (commit),
        .kind_o     (cur_kind),
        .blk_o      (cur_blk),
        .pg_o       (cur_pg)
    );

    spd_prot_store #(.NBLK(NBLK)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .kind_i   (cur_kind),
        .blk_i    (cur_blk),
        .pg_i     (cur_pg),
        .prot_o   (prot_o),
        .page_o   (page_o),
        .wc_req_o (wc_req_o)
    );

    // R2: a write-cycle request follows a STOP
    p_wc_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wc_req_o) |-> $past(stop_i));

    // R2: the request lasts one cycle
    p_wc_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wc_req_o |=> !wc_req_o);

    // R5: the page bit moves only at a STOP
    p_page_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_i |=> $stable(page_o));

    // R4: a clear-all leaves every flag clear
    p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cur_kind == K_CLR) |=> (prot_o == '0));
endmodule

// File: tb/test_spd_cmd_responder.sv
`timescale 1ns/1ps
module test_spd_cmd_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0, busy_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       ack_vld_o, ack_o, wc_req_o, page_o;
    logic [7:0] rd_data_o;
    logic [3:0] prot_o;

    int n_chk = 0, n_fail = 0, wc_cnt = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    spd_cmd_responder i_spd_cmd_responder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .busy_i(busy_i),
        .ack_vld_o(ack_vld_o), .ack_o(ack_o), .rd_data_o(rd_data_o),
        .wc_req_o(wc_req_o), .prot_o(prot_o), .page_o(page_o)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: compares acknowledges against the scoreboard, counts requests
    always @(negedge clk) begin
        if (rst_n && wc_req_o) wc_cnt++;
        if (rst_n && ack_vld_o) begin
            if (exp_q.size() == 0) begin
                check("unexpected ack", 1, 0);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, int'(ack_o), int'(e));
            end
        end
    end

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(logic [7:0] b, bit exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk); byte_i = b; byte_vld_i = 1'b1;
        @(negedge clk); byte_vld_i = 1'b0;
    endtask

    task automatic write_cmd(logic [7:0] c, bit a0, bit a1, bit a2, string tag);
        do_start();
        send(c, a0, tag);
        send(8'h00, a1, tag);
        send(8'h5A, a2, tag);
        do_stop();
    endtask

    initial begin
        #400000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 page", int'(page_o), 0);
        check("R1 prot", int'(prot_o), 0);
        check("R1 wc", int'(wc_req_o), 0);
        check("R1 ackv", int'(ack_vld_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 / R7 queries at reset state
        do_start(); send(8'h65, 1'b1, "R6 query free"); check("R6 rd", int'(rd_data_o), 255); do_stop();
        do_start(); send(8'h6B, 1'b1, "R7 page0 query"); do_stop();

        // R2 protect block 2
        write_cmd(8'h64, 1, 1, 1, "R2 set");
        check("R2 prot", int'(prot_o), 4);
        check("R2 wc", wc_cnt, 1);

        // R3 protect again
        write_cmd(8'h64, 0, 0, 0, "R3 set again");
        check("R3 prot", int'(prot_o), 4);
        check("R3 wc", wc_cnt, 1);

        // R6 query protected and unprotected
        do_start(); send(8'h65, 1'b0, "R6 query prot"); do_stop();
        do_start(); send(8'h63, 1'b1, "R6 query blk1"); do_stop();
        check("R6 state", int'(prot_o), 4);

        // R9 repeated START abort, then early STOP abort
        do_start(); send(8'h60, 1, "R9 rs"); send(8'h00, 1, "R9 rs"); send(8'h00, 1, "R9 rs");
        do_start(); do_stop();
        check("R9 rs prot", int'(prot_o), 4);
        do_start(); send(8'h62, 1, "R9 early"); send(8'h00, 1, "R9 early"); do_stop();
        check("R9 early prot", int'(prot_o), 4);
        check("R9 wc", wc_cnt, 1);

        // R10 busy
        busy_i = 1'b1;
        write_cmd(8'h62, 0, 0, 0, "R10 busy");
        busy_i = 1'b0;
        check("R10 prot", int'(prot_o), 4);
        check("R10 wc", wc_cnt, 1);

        // R5 page 1, then R7 query
        write_cmd(8'h6C, 1, 1, 0, "R5 pg1");
        check("R5 page", int'(page_o), 1);
        check("R5 wc", wc_cnt, 1);
        do_start(); send(8'h6B, 1'b0, "R7 page1 query"); do_stop();

        // R8 unknown addresses
        do_start(); send(8'hA0, 0, "R8 unk"); send(8'h00, 0, "R8 unk"); do_stop();
        do_start(); send(8'h69, 0, "R8 clr rd"); do_stop();
        do_start(); send(8'h6D, 0, "R8 pg1 rd"); do_stop();

        // R11 surplus byte
        do_start(); send(8'h66, 1, "R11"); send(8'h00, 1, "R11"); send(8'h00, 1, "R11");
        send(8'h00, 0, "R11 extra"); do_stop();
        check("R11 prot", int'(prot_o), 4);
        check("R11 wc", wc_cnt, 1);

        // R4 clear-all, twice
        write_cmd(8'h68, 1, 1, 1, "R4 clr");
        check("R4 prot", int'(prot_o), 0);
        check("R4 wc", wc_cnt, 2);
        write_cmd(8'h68, 1, 1, 1, "R4 clr empty");
        check("R4 wc2", wc_cnt, 3);

        // R5 back to page 0
        write_cmd(8'h6A, 1, 1, 0, "R5 pg0");
        check("R5 page0", int'(page_o), 0);

        repeat (4) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule